// File: doc/BRIEF.md
# SPI Byte Master with Selectable Sampling Phase

This block is a byte-wide serial master for a synchronous four-wire link, programmed through a small register bus. Software first sets the serial clock divider, the clock idle level, the sampling phase and the interrupt enable in the configuration register. It then writes a byte to the data register. That write starts a transfer: chip select goes low, eight serial clock pulses shift the byte out most significant bit first, and eight incoming bits are gathered at the same time.

When the last clock pulse has ended, the master releases chip select and returns to idle. It places the received byte in the data register and raises its idle status. If interrupts are enabled, it also gives a single-cycle interrupt pulse. The interrupt comes from the rising edge of the idle status, not from its level. An idle master therefore never holds the line high, and turning the enable on while idle does not cause a pulse.

Output data changes only on the clock edge that is opposite to the sampling edge. Because of this, a byte keeps every bit in place in both phases.

Top module: `spi_byte_master`

## Requirements
- R1: After a synchronous active-low reset, the outputs are: chip select high, serial clock low, serial data out low, interrupt low. The idle status (bit 8 of the data register read) reads 1. The configuration register reads 0.
- R2: A bus write to address 1 (data) while idle starts a transfer of bits [7:0]. Chip select stays low for the whole transfer, and exactly 16 serial clock edges (8 pulses) occur while it is low.
- R3: With phase bit 0 of the configuration register at 0, both ends sample on the leading clock edge. With it at 1, both ends sample on the trailing edge. Serial data out never changes on a sampling edge, so the byte leaves most significant bit first and arrives bit-exact in both phases (0x01 arrives as 0x01).
- R4: Each serial clock half-period lasts prescaler+1 system clocks, with the prescaler in configuration bits [15:8]. The idle status returns exactly 17×(prescaler+1) clocks after the cycle that captured the data write.
- R5: The idle status reads 0 while a transfer runs. After it returns to 1, data register bits [7:0] hold the byte received on serial data in, with the first bit received as the most significant bit.
- R6: When configuration bit 2 (interrupt enable) is 1, the interrupt is high for exactly one clock, in the cycle when the idle status rises. This gives exactly one pulse per byte, and no pulse when the enable is 0.
- R7: Setting the interrupt enable while the master is already idle raises no interrupt.
- R8: A data write while a transfer runs is ignored. The transfer continues with its original byte and timing, and no second transfer follows.
- R9: Configuration bit 1 sets the serial clock idle level (0 idles low, so the leading edge is rising). Chip select rises half a period after the last clock edge, with the clock back at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 configuration, 1 data |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |
| spi_csn | output | 1 | Chip select, active low |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Embedded assertions check several rules on every clock. Serial data out holds still on each sampling edge. Chip select changes only while the clock sits at its idle level. The interrupt never lasts longer than one cycle, and it occurs only together with the release of chip select.

Other behaviour can only be shown by the bench scenarios. A loopback slave model checks bit-exact delivery in both directions and both phases, including the 0x01 case in the trailing-edge phase. The bench also checks the exact completion time for several prescaler values, one interrupt per byte, the absence of a pulse when the enable is set while idle, and that a data write during a transfer is ignored.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
   localparam logic ADDR_CFG  = 1'b0;
   localparam logic ADDR_DATA = 1'b1;
   localparam int   FLAG_PHASE = 0;
   localparam int   FLAG_POL   = 1;
   localparam int   FLAG_IEN   = 2;
   localparam int   PRE_LSB    = 8;

   typedef struct packed {
      logic ien;
      logic pol;
      logic phase;
   } spi_mode_t;
endpackage

// File: rtl/spi_bm_tick.sv
module spi_bm_tick #(
   parameter int PRE_W = 8,
   localparam int PW = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [PW-1:0] pre,
   output logic          tick
);
   generate
      if (PRE_W == 0) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         logic [PW-1:0] cnt;
         assign tick = run && (cnt == pre);
         always_ff @(posedge clk) begin
            if (!rst_n)            cnt <= '0;
            else if (!run || tick) cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift #(
   parameter int BITS = 8,
   localparam int EDGES = 2 * BITS,
   localparam int EW = $clog2(EDGES + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [BITS-1:0] tx,
   input  logic            tick,
   input  logic            phase,
   input  logic            pol,
   input  logic            sdi,
   output logic            busy,
   output logic            sck,
   output logic            sdo,
   output logic            csn,
   output logic [BITS-1:0] rx
);
   logic [BITS-1:0] txs, rxs;
   logic [EW-1:0]   ecnt;
   logic            lead, samp, last_edge;

   initial assert (BITS >= 2) else $error("spi_bm_shift: BITS must be at least 2");

   assign lead      = ~ecnt[0];
   assign samp      = lead ^ phase;
   assign last_edge = (ecnt == EW'(EDGES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         sdo  <= 1'b0;
         csn  <= 1'b1;
         txs  <= '0;
         rxs  <= '0;
         rx   <= '0;
         ecnt <= '0;
      end else if (!busy) begin
         sck <= pol;
         if (start) begin
            busy <= 1'b1;
            csn  <= 1'b0;
            ecnt <= '0;
            if (!phase) begin
               sdo <= tx[BITS-1];
               txs <= tx << 1;
            end else begin
               txs <= tx;
            end
         end
      end else if (tick) begin
         if (ecnt == EW'(EDGES)) begin
            busy <= 1'b0;
            csn  <= 1'b1;
            rx   <= rxs;
         end else begin
            sck  <= ~sck;
            ecnt <= ecnt + 1'b1;
            if (samp) begin
               rxs <= {rxs[BITS-2:0], sdi};
            end else if (phase || !last_edge) begin
               sdo <= txs[BITS-1];
               txs <= txs << 1;
            end
         end
      end
   end

   // R3: data out is frozen on every sampling edge while selected
   a_r3_sdo_still_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (!csn && $past(!csn) && (sck != $past(sck)) && (sck == (phase == pol)))
      |-> (sdo == $past(sdo)));

   // R9: chip select released only with the clock at its idle level
   a_r9_release_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csn) |-> (sck == pol));

   // R2: chip select asserted only with the clock at its idle level
   a_r2_select_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(csn) |-> (sck == pol));
endmodule

// File: rtl/spi_bm_irq.sv
module spi_bm_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic ien,
   output logic irq
);
   logic done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) done_q <= 1'b1;
      else        done_q <= done;
   end

   assign irq = ien & done & ~done_q;

   // R6: never wider than one cycle
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
   parameter int BUS_W = 16,
   parameter int BITS  = 8,
   parameter int PRE_W = 8,
   localparam int PW = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             spi_sck,
   output logic             spi_sdo,
   input  logic             spi_sdi,
   output logic             spi_csn,
   output logic             irq
);
   import spi_bm_pkg::*;

   initial assert (spi_bm_pkg::PRE_LSB + PRE_W <= BUS_W && BITS + 1 <= BUS_W && BITS <= spi_bm_pkg::PRE_LSB)
      else $error("spi_byte_master: field layout does not fit BUS_W");

   spi_mode_t       mode_q;
   logic [PW-1:0]   pre_q;
   logic            busy, done, start, tick;
   logic [BITS-1:0] rx;

   assign done  = ~busy;
   assign start = bus_wr && (bus_addr == ADDR_DATA) && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         pre_q  <= '0;
      end else if (bus_wr && bus_addr == ADDR_CFG) begin
         mode_q.phase <= bus_wdata[FLAG_PHASE];
         mode_q.pol   <= bus_wdata[FLAG_POL];
         mode_q.ien   <= bus_wdata[FLAG_IEN];
         if (PRE_W > 0) pre_q <= bus_wdata[PRE_LSB +: PW];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_CFG) begin
         bus_rdata[FLAG_PHASE] = mode_q.phase;
         bus_rdata[FLAG_POL]   = mode_q.pol;
         bus_rdata[FLAG_IEN]   = mode_q.ien;
         if (PRE_W > 0) bus_rdata[PRE_LSB +: PW] = pre_q;
      end else begin
         bus_rdata[BITS-1:0] = rx;
         bus_rdata[BITS]     = done;
      end
   end

   spi_bm_tick #(.PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .pre(pre_q), .tick(tick)
   );

   spi_bm_shift #(.BITS(BITS)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx(bus_wdata[BITS-1:0]),
      .tick(tick), .phase(mode_q.phase), .pol(mode_q.pol), .sdi(spi_sdi),
      .busy(busy), .sck(spi_sck), .sdo(spi_sdo), .csn(spi_csn), .rx(rx)
   );

   spi_bm_irq u_irq (
      .clk(clk), .rst_n(rst_n), .done(done), .ien(mode_q.ien), .irq(irq)
   );

   // R6: a pulse accompanies the end of a transfer and nothing else
   a_r6_pulse_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $rose(spi_csn));

   // R7: no pulse while the select line was already high
   a_r7_no_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(spi_csn) && spi_csn) |-> !irq);
endmodule

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        spi_sck, spi_sdo, spi_csn, irq;
   logic        spi_sdi = 1'b0;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int sck_edges = 0;
   logic       m_phase = 1'b0, m_pol = 1'b0;
   logic [7:0] s_resp = '0, s_cap = '0;
   int         s_lead = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_byte_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_sdo(spi_sdo), .spi_sdi(spi_sdi), .spi_csn(spi_csn), .irq(irq)
   );

   always @(negedge clk) if (rst_n && irq === 1'b1) irq_cnt++;

   // loopback slave: mirrors the master's phase rules
   always @(negedge spi_csn) begin
      s_lead = 0;
      s_cap = '0;
      sck_edges = 0;
      if (!m_phase) spi_sdi = s_resp[7];
   end

   always @(spi_sck) begin
      if (rst_n && spi_csn === 1'b0) begin
         sck_edges++;
         if (spi_sck != m_pol) begin
            if (!m_phase) s_cap = {s_cap[6:0], spi_sdo};
            else          spi_sdi = s_resp[7 - s_lead];
            s_lead++;
         end else begin
            if (m_phase)         s_cap = {s_cap[6:0], spi_sdo};
            else if (s_lead < 8) spi_sdi = s_resp[7 - s_lead];
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] cfg_word(input int pre, input bit ph, pol, ie);
      return {pre[7:0], 5'b0, ie, pol, ph};
   endfunction

   function automatic int exp_cycles(input int pre);
      return 17 * (pre + 1);
   endfunction

   task automatic wr(input logic a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b1;
   endtask

   task automatic xfer(input logic [7:0] tx, resp, input int pre,
                       input bit ph, pol, ie, poke);
      int n;
      int irq0;
      m_phase = ph; m_pol = pol; s_resp = resp;
      wr(1'b0, cfg_word(pre, ph, pol, ie));
      irq0 = irq_cnt;
      wr(1'b1, {8'h00, tx});
      n = 0;
      check(bus_rdata[8] == 1'b0, "R5 busy status", bus_rdata[8], 0);
      check(spi_csn == 1'b0, "R2 select low", spi_csn, 0);
      while (!bus_rdata[8] && n < 5000) begin
         if (poke) begin
            bus_wr = (n == 2);
            bus_wdata = {8'h00, ~tx};
         end
         @(negedge clk);
         n++;
      end
      bus_wr = 1'b0;
      check(n == exp_cycles(pre), "R4 completion time", n, exp_cycles(pre));
      check(bus_rdata[7:0] == resp, "R5 received byte", bus_rdata[7:0], resp);
      check(s_cap == tx, "R3 slave got exact byte", s_cap, tx);
      check(sck_edges == 16, "R2 clock edges", sck_edges, 16);
      check(spi_csn == 1'b1 && spi_sck == pol, "R9 idle level at release",
            {spi_csn, spi_sck}, {1'b1, pol});
      repeat (3) @(negedge clk);
      check(irq_cnt - irq0 == (ie ? 1 : 0), "R6 one pulse per byte", irq_cnt - irq0, ie ? 1 : 0);
      if (poke) begin
         check(spi_csn == 1'b1, "R8 no second transfer", spi_csn, 1);
         check(bus_rdata[8] == 1'b1, "R8 still idle", bus_rdata[8], 1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed_v;
      int i0;
      seed_v = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      bus_addr = 1'b1;
      #1;
      check(spi_csn == 1 && spi_sck == 0 && spi_sdo == 0 && irq == 0,
            "R1 reset outputs", {spi_csn, spi_sck, spi_sdo, irq}, 4'b1000);
      check(bus_rdata[8] == 1'b1, "R1 idle after reset", bus_rdata[8], 1);
      bus_addr = 1'b0;
      #1;
      check(bus_rdata == 16'h0, "R1 config cleared", bus_rdata, 0);
      bus_addr = 1'b1;

      // R7: enable while idle
      i0 = irq_cnt;
      wr(1'b0, cfg_word(0, 0, 0, 1));
      repeat (5) @(negedge clk);
      check(irq_cnt == i0, "R7 enable while idle", irq_cnt - i0, 0);

      // directed corners
      xfer(8'h01, 8'h80, 1, 1, 0, 1, 0);   // R3 trailing-edge 0x01
      xfer(8'h01, 8'h01, 0, 0, 0, 1, 0);   // R3 leading edge
      xfer(8'hFF, 8'h00, 0, 1, 1, 0, 0);   // R9 idle high, R6 no pulse
      xfer(8'h80, 8'hA5, 3, 0, 1, 1, 0);
      xfer(8'h3C, 8'hC3, 2, 1, 0, 1, 1);   // R8 write while busy
      xfer(8'h96, 8'h69, 0, 0, 0, 1, 1);   // R8 leading edge mode

      for (int k = 0; k < 24; k++) begin
         xfer($urandom_range(255), $urandom_range(255), $urandom_range(4),
              $urandom_range(1), $urandom_range(1), $urandom_range(1), 1'b0);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule